// File: doc/BRIEF.md
# Dithered Third-Order Cascaded Sigma-Delta Modulator

This block produces the per-cycle modulus offset for a fractional-N divider. On every reference clock it takes a 20-bit fraction, treated as a value in [0, 1) scaled by 2^20. It returns a small signed integer, and the divider adds that integer to its integer divide value. Over time, the average of the returned integers equals the fraction. The modulator is a cascade of three first-order accumulators. The carries of those accumulators are combined by a noise-cancelling network, so that quantization error is pushed towards high frequency.

A rational DC fraction can make the cascade fall into a short state cycle, and a short cycle shows up as spurs. Three independent measures are available to lengthen or break such cycles:
- a pseudo-random bit, taken from an on-chip shift register, added into the input's least significant bit;
- a mode that sets the two lowest input bits;
- a programmable start value for the first accumulator.

Top module: `frac_sdm_mash3`

## Requirements
- R1: While `rst_n` is low, `dsm_out` is 0. The first rising clock edge after release is a priming edge: it loads `seed` into stage 1, holds stages 2 and 3 at 0, and leaves `dsm_out` at 0. Inputs are first used on the second edge after release.
- R2: Each stage holds a 20-bit value acc and forms acc + addend (+ carry-in for stage 1). Bit 20 of that sum is the stage carry c, and the low 20 bits are the residue, which is stored. Stage 1 adds the conditioned input word. Stage 2 adds the stage-1 residue of the same cycle, and stage 3 adds the stage-2 residue of the same cycle. The output is y[n] = c1[n] + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2]. The history terms are 0 at the first processed cycle.
- R3: `dsm_out` is a 4-bit two's-complement value that always lies between −3 and +4.
- R4: `dsm_out` is registered. The result for the input present at a rising edge appears right after that edge.
- R5: With `lsb_force_en` high, bits 1 and 0 of the input word are replaced by 1 before stage 1.
- R6: With `dither_en` high, stage 1 receives a carry-in equal to bit 22 of a 23-bit shift register. The register is reset to 23'h2B1F3D. On every edge after the priming edge it shifts left, taking in bit 22 XOR bit 17 at bit 0. With `dither_en` low, the carry-in is 0.
- R7: The value of `seed` at the priming edge becomes stage 1's starting value, and it shapes the first carries.
- R8: With both measures off, `seed` at 0 and the fraction equal to a/b with a+b odd, the output sequence repeats every 2·b cycles from the third processed cycle on. Examples are 1/4, which repeats every 8 cycles, and 3/8, which repeats every 16.
- R9: Over N processed cycles, the sum of the outputs stays within 4 of N·w/2^20. Here w is the conditioned word, plus 0.5 when dither is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| frac_in | input | 20 | Fraction word, scaled by 2^20 |
| lsb_force_en | input | 1 | Set the two lowest input bits |
| dither_en | input | 1 | Add the pseudo-random carry-in |
| seed | input | 20 | Stage-1 start value, taken at the priming edge |
| dsm_out | output | 4 | Signed modulus offset, range −3..+4 |

## Verification
Every result is due one edge after the input it belongs to, and the priming edge that follows reset release produces no result. The bench therefore drives each input on a falling edge and reads `dsm_out` on the next falling edge. It steps an independent model of the cascade once for each of those edges, so the model and the design stay in step. Checks of the reset value are made a short delay after `rst_n` falls, and again after the priming edge. The long-run mean and the repetition checks use sequences gathered in the same way.

// File: rtl/frac_sdm_pkg.sv
package frac_sdm_pkg;

  localparam int unsigned FRAC_W_DEF   = 20;
  localparam int unsigned OUT_W_DEF    = 4;
  localparam int unsigned N_STAGE_DEF  = 3;
  localparam int unsigned PRBS_W_DEF   = 23;
  localparam int unsigned PRBS_TAP_DEF = 18;
  localparam logic [PRBS_W_DEF-1:0] PRBS_INIT_DEF = 23'h2B1F3D;

  typedef enum logic {
    PH_PRIME = 1'b0,
    PH_RUN   = 1'b1
  } sdm_phase_e;

endpackage

// File: rtl/frac_sdm_prbs.sv
module frac_sdm_prbs #(
  parameter int unsigned         W    = 23,
  parameter int unsigned         TAP  = 18,
  parameter logic [W-1:0]        INIT = 23'h2B1F3D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state_o,
  output logic         bit_o
);

  logic [W-1:0] sr_q;
  logic [W-1:0] sr_d;
  logic         fb;

  always_comb begin
    fb   = sr_q[W-1] ^ sr_q[TAP-1];
    sr_d = sr_q;
    if (adv) begin
      sr_d = {sr_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= INIT;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign state_o = sr_q;
  assign bit_o   = sr_q[W-1];

endmodule

// File: rtl/frac_sdm_cond.sv
module frac_sdm_cond #(
  parameter int unsigned W = 20
) (
  input  logic [W-1:0] frac_in,
  input  logic         lsb_force_en,
  input  logic         dither_en,
  input  logic         prbs_bit,
  output logic [W-1:0] word_o,
  output logic         cin_o
);

  always_comb begin
    word_o = frac_in;
    if (lsb_force_en) begin
      word_o[1:0] = 2'b11;
    end
    cin_o = dither_en & prbs_bit;
  end

endmodule

// File: rtl/frac_sdm_stage.sv
module frac_sdm_stage #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] addend,
  input  logic         cin,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] res_o,
  output logic         carry_o
);

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic [W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, addend} + {{W{1'b0}}, cin};
    res_o   = sum[W-1:0];
    carry_o = sum[W];
    acc_d   = acc_q;
    if (load) begin
      acc_d = load_val;
    end else if (adv) begin
      acc_d = sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/frac_sdm_combine.sv
module frac_sdm_combine #(
  parameter int unsigned OUT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    c1,
  input  logic                    c2,
  input  logic                    c3,
  output logic signed [OUT_W-1:0] y_o
);

  logic             c2_q, c3_q1, c3_q2;
  logic             c2_d, c3_d1, c3_d2;
  logic [OUT_W-1:0] y_q, y_d, total;

  always_comb begin
    total = OUT_W'(c1)
          + OUT_W'(c2) - OUT_W'(c2_q)
          + OUT_W'(c3) - OUT_W'({c3_q1, 1'b0}) + OUT_W'(c3_q2);
    y_d   = y_q;
    c2_d  = c2_q;
    c3_d1 = c3_q1;
    c3_d2 = c3_q2;
    if (adv) begin
      y_d   = total;
      c2_d  = c2;
      c3_d1 = c3;
      c3_d2 = c3_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q   <= '0;
      c2_q  <= 1'b0;
      c3_q1 <= 1'b0;
      c3_q2 <= 1'b0;
    end else begin
      y_q   <= y_d;
      c2_q  <= c2_d;
      c3_q1 <= c3_d1;
      c3_q2 <= c3_d2;
    end
  end

  assign y_o = $signed(y_q);

endmodule

// File: rtl/frac_sdm_mash3.sv
module frac_sdm_mash3
  import frac_sdm_pkg::*;
#(
  parameter int unsigned              FRAC_W    = FRAC_W_DEF,
  parameter int unsigned              OUT_W     = OUT_W_DEF,
  parameter int unsigned              PRBS_W    = PRBS_W_DEF,
  parameter int unsigned              PRBS_TAP  = PRBS_TAP_DEF,
  parameter logic [PRBS_W_DEF-1:0]    PRBS_INIT = PRBS_INIT_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FRAC_W-1:0]        frac_in,
  input  logic                     lsb_force_en,
  input  logic                     dither_en,
  input  logic [FRAC_W-1:0]        seed,
  output logic signed [OUT_W-1:0]  dsm_out
);

  localparam int unsigned NS = N_STAGE_DEF;

  sdm_phase_e phase_q, phase_d;
  logic       do_load, do_run;

  logic [PRBS_W-1:0]          prbs_state;
  logic                       prbs_bit;
  logic [FRAC_W-1:0]          cond_word;
  logic                       cond_cin;
  logic [NS-1:0][FRAC_W-1:0]  st_acc;
  logic [NS-1:0][FRAC_W-1:0]  st_res;
  logic [NS-1:0]              st_carry;

  always_comb begin
    phase_d = PH_RUN;
    do_load = (phase_q == PH_PRIME);
    do_run  = (phase_q == PH_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PRIME;
    end else begin
      phase_q <= phase_d;
    end
  end

  frac_sdm_prbs #(
    .W    (PRBS_W),
    .TAP  (PRBS_TAP),
    .INIT (PRBS_INIT[PRBS_W-1:0])
  ) prbs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (do_run),
    .state_o (prbs_state),
    .bit_o   (prbs_bit)
  );

  frac_sdm_cond #(.W(FRAC_W)) cond_i (
    .frac_in      (frac_in),
    .lsb_force_en (lsb_force_en),
    .dither_en    (dither_en),
    .prbs_bit     (prbs_bit),
    .word_o       (cond_word),
    .cin_o        (cond_cin)
  );

  for (genvar k = 0; k < NS; k++) begin : g_stage
    logic [FRAC_W-1:0] addend;
    logic [FRAC_W-1:0] ld_val;
    logic              cin;
    if (k == 0) begin : g_first
      assign addend = cond_word;
      assign ld_val = seed;
      assign cin    = cond_cin;
    end else begin : g_rest
      assign addend = st_res[k-1];
      assign ld_val = '0;
      assign cin    = 1'b0;
    end
    frac_sdm_stage #(.W(FRAC_W)) stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (do_load),
      .adv      (do_run),
      .load_val (ld_val),
      .addend   (addend),
      .cin      (cin),
      .acc_o    (st_acc[k]),
      .res_o    (st_res[k]),
      .carry_o  (st_carry[k])
    );
  end

  frac_sdm_combine #(.OUT_W(OUT_W)) comb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (do_run),
    .c1    (st_carry[0]),
    .c2    (st_carry[1]),
    .c3    (st_carry[2]),
    .y_o   (dsm_out)
  );

endmodule

// File: rtl/frac_sdm_mash3_chk.sv
module frac_sdm_mash3_chk #(
  parameter int unsigned FRAC_W = 20,
  parameter int unsigned OUT_W  = 4,
  parameter int unsigned PRBS_W = 23,
  parameter int unsigned NS     = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       phase_run,
  input logic [FRAC_W-1:0]          seed,
  input logic                       lsb_force_en,
  input logic                       dither_en,
  input logic [FRAC_W-1:0]          cond_word,
  input logic                       cond_cin,
  input logic [PRBS_W-1:0]          prbs_state,
  input logic [NS-1:0][FRAC_W-1:0]  st_acc,
  input logic [NS-1:0][FRAC_W-1:0]  st_res,
  input logic [NS-1:0]              st_carry,
  input logic signed [OUT_W-1:0]    dsm_out
);

  // R3
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsm_out >= -4'sd3) && (dsm_out <= 4'sd4));

  // R1
  prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_run |=> (dsm_out == '0) && (st_acc[1] == '0) && (st_acc[2] == '0));

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_run |=> st_acc[0] == $past(seed));

  // R5
  lsb_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsb_force_en |-> cond_word[1:0] == 2'b11);

  // R6
  dither_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dither_en |-> !cond_cin);

  // R6
  prbs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prbs_state != '0);

  // R6
  prbs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_run |=> prbs_state != $past(prbs_state));

  // R2
  last_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_carry[NS-1] |-> st_res[NS-1] < st_acc[NS-1]);

  // R2
  last_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_carry[NS-1] |-> st_res[NS-1] >= st_acc[NS-1]);

endmodule

bind frac_sdm_mash3 frac_sdm_mash3_chk #(
  .FRAC_W (FRAC_W),
  .OUT_W  (OUT_W),
  .PRBS_W (PRBS_W),
  .NS     (NS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase_run    (do_run),
  .seed         (seed),
  .lsb_force_en (lsb_force_en),
  .dither_en    (dither_en),
  .cond_word    (cond_word),
  .cond_cin     (cond_cin),
  .prbs_state   (prbs_state),
  .st_acc       (st_acc),
  .st_res       (st_res),
  .st_carry     (st_carry),
  .dsm_out      (dsm_out)
);

// File: tb/frac_sdm_mash3_tb_top.sv
`timescale 1ns/1ps
module frac_sdm_mash3_tb_top;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [19:0]       frac_in = '0;
  logic              lsb_force_en = 1'b0;
  logic              dither_en = 1'b0;
  logic [19:0]       seed = '0;
  logic signed [3:0] dsm_out;

  always #2 clk = ~clk;

  frac_sdm_mash3 dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .frac_in      (frac_in),
    .lsb_force_en (lsb_force_en),
    .dither_en    (dither_en),
    .seed         (seed),
    .dsm_out      (dsm_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [19:0] m_acc1, m_acc2, m_acc3;
  logic        m_c2p, m_c3p1, m_c3p2;
  logic [22:0] m_prbs;

  int ybuf [64];
  int y_min = 99;
  int y_max = -99;

  // each entry: frac, force, dither, seed
  localparam logic [41:0] VEC [8] = '{
    {20'h40000, 1'b0, 1'b0, 20'h00000},
    {20'h60000, 1'b0, 1'b0, 20'h00001},
    {20'h12345, 1'b1, 1'b0, 20'h80000},
    {20'hABCDE, 1'b0, 1'b1, 20'h00000},
    {20'hFFFFF, 1'b1, 1'b1, 20'hFFFFF},
    {20'h00000, 1'b0, 1'b0, 20'h7FFFF},
    {20'h00003, 1'b1, 1'b1, 20'h00000},
    {20'h7FFFF, 1'b0, 1'b1, 20'h12345}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R2 R5 R6: one model step for the input presented at the next edge
  task automatic model_step(input logic [19:0] x, input logic frc, input logic dth,
                            output int y);
    logic [19:0] w;
    logic [20:0] s1, s2, s3;
    logic        d;
    w  = frc ? {x[19:2], 2'b11} : x;
    d  = dth ? m_prbs[22] : 1'b0;
    s1 = {1'b0, m_acc1} + {1'b0, w} + {20'b0, d};
    s2 = {1'b0, m_acc2} + {1'b0, s1[19:0]};
    s3 = {1'b0, m_acc3} + {1'b0, s2[19:0]};
    y  = int'(s1[20]) + int'(s2[20]) - int'(m_c2p)
       + int'(s3[20]) - 2 * int'(m_c3p1) + int'(m_c3p2);
    m_acc1 = s1[19:0];
    m_acc2 = s2[19:0];
    m_acc3 = s3[19:0];
    m_c3p2 = m_c3p1;
    m_c3p1 = s3[20];
    m_c2p  = s2[20];
    m_prbs = {m_prbs[21:0], m_prbs[22] ^ m_prbs[17]};
  endtask

  // R1: reset, priming edge, model init; ends just after a falling edge
  task automatic do_reset(input logic [19:0] sd);
    @(negedge clk);
    rst_n = 1'b0;
    seed  = sd;
    #1;
    check("R1 out during reset", int'(dsm_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out after priming edge", int'(dsm_out), 0);
    m_acc1 = sd; m_acc2 = '0; m_acc3 = '0;
    m_c2p = 1'b0; m_c3p1 = 1'b0; m_c3p2 = 1'b0;
    m_prbs = 23'h2B1F3D;
  endtask

  // drive one input at a falling edge, read result at the next falling edge
  task automatic step(input logic [19:0] x, input logic frc, input logic dth,
                      input string req, output int got);
    int exp;
    frac_in = x; lsb_force_en = frc; dither_en = dth;
    model_step(x, frc, dth, exp);
    @(negedge clk);
    got = int'(dsm_out);
    check(req, got, exp);
  endtask

  task automatic run_period(input logic [19:0] x, input int per, input string req);
    int g;
    do_reset(20'h0);
    for (int n = 0; n < 2 + 2 * per; n++) begin
      step(x, 1'b0, 1'b0, "R2 model", g);
      if (n < 64) ybuf[n] = g;
    end
    for (int n = 2; n < 2 + per; n++) begin
      check(req, ybuf[n + per], ybuf[n]);
    end
  endtask

  task automatic run_mean(input logic [19:0] x, input logic frc, input logic dth,
                          input logic [19:0] sd, input int nstep);
    int    g;
    longint sum;
    real   w, expv, err;
    sum = 0;
    do_reset(sd);
    for (int n = 0; n < nstep; n++) begin
      step(x, frc, dth, "R2 model", g);
      sum += g;
    end
    w = real'(frc ? {x[19:2], 2'b11} : x) + (dth ? 0.5 : 0.0);
    expv = real'(nstep) * w / 1048576.0;
    err = real'(sum) - expv;
    if (err < 0.0) err = -err;
    check("R9 mean within 4", int'(err <= 4.0), 1);
  endtask

  initial begin
    int g;
    rst_n = 1'b0;

    // table walk: R2, R4, R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      logic [41:0] e;
      e = VEC[v];
      do_reset(e[19:0]);
      for (int n = 0; n < 40; n++) begin
        step(e[41:22], e[21], e[20], "R2 R5 R6 R7 stepwise", g);
        if (g < y_min) y_min = g;
        if (g > y_max) y_max = g;
      end
    end
    // R3
    check("R3 min >= -3", int'(y_min >= -3), 1);
    check("R3 max <= 4", int'(y_max <= 4), 1);

    // R4 R7: seed all ones plus input 1 carries on the first processed edge
    do_reset(20'hFFFFF);
    step(20'h00001, 1'b0, 1'b0, "R4 R7 first result", g);
    check("R4 R7 seed carry gives 1", g, 1);
    do_reset(20'h00000);
    step(20'h00001, 1'b0, 1'b0, "R4 zero seed", g);
    check("R7 zero seed gives 0", g, 0);

    // R5: forcing makes input 0 behave like 3
    do_reset(20'hFFFFD);
    step(20'h00000, 1'b1, 1'b0, "R5 forced", g);
    check("R5 forced lsbs reach carry", g, 1);

    // R8 repetition
    run_period(20'h40000, 8, "R8 period 1/4");
    run_period(20'h60000, 16, "R8 period 3/8");

    // R9 long-run mean
    run_mean(20'h12345, 1'b1, 1'b0, 20'h00000, 8192);
    run_mean(20'hCAFE1, 1'b0, 1'b1, 20'h31415, 8192);
    run_mean(20'hFFFFF, 1'b1, 1'b1, 20'h00000, 8192);

    // R1: reset asserted mid-run clears output at once
    do_reset(20'hFFFFF);
    step(20'h00001, 1'b0, 1'b0, "R1 pre", g);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", int'(dsm_out), 0);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

endmodule